// File: doc/BRIEF.md
# Sector-Mapped Space-Vector Switching Sequencer

This block turns one sampling period's worth of space-vector data into a per-clock level command for the three phases of an n-level inverter. It receives the per-phase levels of the three nearest vectors, expressed as if the reference sat in the first sector, the dwell counts of those vectors and the actual sector number. It then plays the vectors out as a symmetric seven-segment pattern over a fixed period of `TS_CYC` clocks. The zero-side vector opens, centres and closes the period. The two active vectors sit between, in mirrored order.

Each period the first-sector levels are rotated between phases and, in even sectors, negated, so one set of states serves all six sectors. The order of the two active vectors is swapped in even sectors. New data is taken only at the period boundary. Data whose dwells overrun the period, or whose sector code is out of range, is refused. In that case the last commanded levels are frozen for that period and a flag is raised.

Top module: `svs_sequencer`

## Requirements
- R1: `period_start_o` is high for exactly one cycle every `TS_CYC` cycles; the first period begins with the first clock edge after reset is released.
- R2: Inputs are sampled only at the clock edge that begins a period; changes at other times have no effect on the outputs until the following period.
- R3: In sectors 1, 3 and 5 the period is laid out as Z(e), V1(h1), V2(h2), Z(c), V2(h2), V1(h1), Z(e). Here Z is the `vz_*` vector, e = t0/4, h1 = t1/2, h2 = t2/2 (integer division), and the centre c = `TS_CYC` − 2e − 2h1 − 2h2 absorbs all remainders and unused time.
- R4: In sectors 2, 4 and 6 the roles of V1 and V2 in the layout of R3 are swapped, including which dwell sets each half length.
- R5: The sector code is the binary value 1..6. With first-sector levels (a, b, c) for phases (u, v, w), the outputs (u, v, w) for each sector are:
  - sector 1: (a, b, c)
  - sector 2: (−b, −c, −a)
  - sector 3: (c, a, b)
  - sector 4: (−a, −b, −c)
  - sector 5: (b, c, a)
  - sector 6: (−c, −a, −b)

  Negation is exact two's-complement on `LW`-bit levels.
- R6: A segment whose length works out to zero is skipped entirely, and its neighbours join directly.
- R7: If t0 + t1 + t2 exceeds `TS_CYC` at a boundary, `dwell_err_o` is high for that whole period. The three outputs then stay at the values they had in the last cycle of the previous period.
- R8: A sector code of 0 or 7 at a boundary is handled exactly as in R7.
- R9: After a refused period, the next valid inputs are laid out normally from their own boundary.
- R10: While reset is asserted, all three level outputs are 0, and `period_start_o` and `dwell_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 3 | Actual sector, 1..6 |
| vz_u_i | input | LW | Zero-side vector, phase u level (signed) |
| vz_v_i | input | LW | Zero-side vector, phase v level |
| vz_w_i | input | LW | Zero-side vector, phase w level |
| v1_u_i | input | LW | First active vector, phase u level |
| v1_v_i | input | LW | First active vector, phase v level |
| v1_w_i | input | LW | First active vector, phase w level |
| v2_u_i | input | LW | Second active vector, phase u level |
| v2_v_i | input | LW | Second active vector, phase v level |
| v2_w_i | input | LW | Second active vector, phase w level |
| t0_i | input | TW | Dwell count of the zero-side vector |
| t1_i | input | TW | Dwell count of the first active vector |
| t2_i | input | TW | Dwell count of the second active vector |
| lvl_u_o | output | LW | Signed level command, phase u |
| lvl_v_o | output | LW | Signed level command, phase v |
| lvl_w_o | output | LW | Signed level command, phase w |
| period_start_o | output | 1 | High in the first cycle of each period |
| dwell_err_o | output | 1 | High for a whole period whose inputs were refused |

## Verification
Inputs present at the boundary edge govern the outputs from the very next cycle, which is the first cycle of the new period with `period_start_o` high. Each of the following `TS_CYC` − 1 cycles then shows the next step of the layout, with no further register delay. The bench therefore builds the whole expected period as a queue at the moment it drives the boundary inputs. It pops one entry per cycle and compares on the falling edge, so each value is checked in the cycle after the edge that produced it. Inputs are scrambled mid-period to show they are ignored until the following boundary.

// File: rtl/svs_pkg.sv
package svs_pkg;

  typedef enum logic [1:0] {
    PICK_Z = 2'd0,
    PICK_A = 2'd1,
    PICK_B = 2'd2
  } pick_e;

  function automatic logic sector_ok(input logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd6);
  endfunction

endpackage

// File: rtl/svs_sector_map.sv
module svs_sector_map #(
  parameter int LW = 3
) (
  input  logic [2:0]           sector_i,
  input  logic signed [LW-1:0] su_i,
  input  logic signed [LW-1:0] sv_i,
  input  logic signed [LW-1:0] sw_i,
  output logic signed [LW-1:0] mu_o,
  output logic signed [LW-1:0] mv_o,
  output logic signed [LW-1:0] mw_o
);

  always_comb begin
    case (sector_i)
      3'd2: begin mu_o = -sv_i; mv_o = -sw_i; mw_o = -su_i; end
      3'd3: begin mu_o =  sw_i; mv_o =  su_i; mw_o =  sv_i; end
      3'd4: begin mu_o = -su_i; mv_o = -sv_i; mw_o = -sw_i; end
      3'd5: begin mu_o =  sv_i; mv_o =  sw_i; mw_o =  su_i; end
      3'd6: begin mu_o = -sw_i; mv_o = -su_i; mw_o = -sv_i; end
      default: begin mu_o = su_i; mv_o = sv_i; mw_o = sw_i; end
    endcase
  end

endmodule

// File: rtl/svs_seg_plan.sv
module svs_seg_plan #(
  parameter int TW     = 6,
  parameter int TS_CYC = 40
) (
  input  logic [TW-1:0]      t0_i,
  input  logic [TW-1:0]      t1_i,
  input  logic [TW-1:0]      t2_i,
  input  logic               swap_i,
  output logic [5:0][TW-1:0] bnd_o
);

  logic [TW-1:0] edge_len;
  logic [TW-1:0] half_a;
  logic [TW-1:0] half_b;

  always_comb begin
    edge_len = t0_i >> 2;
    half_a   = swap_i ? (t2_i >> 1) : (t1_i >> 1);
    half_b   = swap_i ? (t1_i >> 1) : (t2_i >> 1);
    bnd_o[0] = edge_len;
    bnd_o[1] = bnd_o[0] + half_a;
    bnd_o[2] = bnd_o[1] + half_b;
    // centre segment takes every remainder and the unused time
    bnd_o[3] = TW'(TS_CYC) - bnd_o[2];
    bnd_o[4] = bnd_o[3] + half_b;
    bnd_o[5] = bnd_o[4] + half_a;
  end

endmodule

// File: rtl/svs_seg_select.sv
module svs_seg_select
  import svs_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic [TW-1:0]      pos_i,
  input  logic [5:0][TW-1:0] bnd_i,
  output pick_e              pick_o
);

  logic [5:0] past_bnd;

  for (genvar k = 0; k < 6; k++) begin : g_cmp
    assign past_bnd[k] = (pos_i >= bnd_i[k]);
  end

  // boundaries never decrease, so past_bnd is a thermometer code
  always_comb begin
    case ($countones(past_bnd))
      1:       pick_o = PICK_A;
      2:       pick_o = PICK_B;
      4:       pick_o = PICK_B;
      5:       pick_o = PICK_A;
      default: pick_o = PICK_Z;
    endcase
  end

endmodule

// File: rtl/svs_sequencer.sv
module svs_sequencer
  import svs_pkg::*;
#(
  parameter int  LEVELS = 7,
  parameter int  TS_CYC = 40,
  localparam int LW     = $clog2((LEVELS - 1) / 2 + 1) + 1,
  localparam int TW     = $clog2(TS_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           sector_i,
  input  logic signed [LW-1:0] vz_u_i,
  input  logic signed [LW-1:0] vz_v_i,
  input  logic signed [LW-1:0] vz_w_i,
  input  logic signed [LW-1:0] v1_u_i,
  input  logic signed [LW-1:0] v1_v_i,
  input  logic signed [LW-1:0] v1_w_i,
  input  logic signed [LW-1:0] v2_u_i,
  input  logic signed [LW-1:0] v2_v_i,
  input  logic signed [LW-1:0] v2_w_i,
  input  logic [TW-1:0]        t0_i,
  input  logic [TW-1:0]        t1_i,
  input  logic [TW-1:0]        t2_i,
  output logic signed [LW-1:0] lvl_u_o,
  output logic signed [LW-1:0] lvl_v_o,
  output logic signed [LW-1:0] lvl_w_o,
  output logic                 period_start_o,
  output logic                 dwell_err_o
);

  localparam int SW = TW + 2;

  // ---------------- input side: map and plan ----------------
  logic signed [LW-1:0] in_st  [3][3];
  logic signed [LW-1:0] map_st [3][3];

  assign in_st[0][0] = vz_u_i;
  assign in_st[0][1] = vz_v_i;
  assign in_st[0][2] = vz_w_i;
  assign in_st[1][0] = v1_u_i;
  assign in_st[1][1] = v1_v_i;
  assign in_st[1][2] = v1_w_i;
  assign in_st[2][0] = v2_u_i;
  assign in_st[2][1] = v2_v_i;
  assign in_st[2][2] = v2_w_i;

  for (genvar k = 0; k < 3; k++) begin : g_map
    svs_sector_map #(.LW(LW)) u_map (
      .sector_i (sector_i),
      .su_i     (in_st[k][0]),
      .sv_i     (in_st[k][1]),
      .sw_i     (in_st[k][2]),
      .mu_o     (map_st[k][0]),
      .mv_o     (map_st[k][1]),
      .mw_o     (map_st[k][2])
    );
  end

  logic              even_in;
  logic [5:0][TW-1:0] bnd_in;
  logic [SW-1:0]     dwell_sum;
  logic              bad_in;

  assign even_in = ~sector_i[0];

  svs_seg_plan #(.TW(TW), .TS_CYC(TS_CYC)) u_plan (
    .t0_i   (t0_i),
    .t1_i   (t1_i),
    .t2_i   (t2_i),
    .swap_i (even_in),
    .bnd_o  (bnd_in)
  );

  assign dwell_sum = SW'(t0_i) + SW'(t1_i) + SW'(t2_i);
  assign bad_in    = (dwell_sum > SW'(TS_CYC)) || !sector_ok(sector_i);

  // ---------------- state ----------------
  logic [TW-1:0]        pos_q, pos_d;
  logic                 err_q, err_d;
  logic [5:0][TW-1:0]   shd_bnd_q, shd_bnd_d;
  logic signed [LW-1:0] shd_z_q [3];
  logic signed [LW-1:0] shd_a_q [3];
  logic signed [LW-1:0] shd_b_q [3];
  logic signed [LW-1:0] shd_z_d [3];
  logic signed [LW-1:0] shd_a_d [3];
  logic signed [LW-1:0] shd_b_d [3];
  logic signed [LW-1:0] hold_q  [3];
  logic signed [LW-1:0] hold_d  [3];
  logic signed [LW-1:0] live    [3];
  logic signed [LW-1:0] lvl     [3];

  logic  boundary;
  logic  shd_en;
  pick_e pick;

  assign boundary = (pos_q == TW'(TS_CYC - 1));
  assign shd_en   = boundary & ~bad_in;

  svs_seg_select #(.TW(TW)) u_sel (
    .pos_i  (pos_q),
    .bnd_i  (shd_bnd_q),
    .pick_o (pick)
  );

  // ---------------- next state ----------------
  always_comb begin
    pos_d     = boundary ? '0 : pos_q + TW'(1);
    err_d     = boundary ? bad_in : err_q;
    shd_bnd_d = bnd_in;
    for (int p = 0; p < 3; p++) begin
      shd_z_d[p] = map_st[0][p];
      shd_a_d[p] = even_in ? map_st[2][p] : map_st[1][p];
      shd_b_d[p] = even_in ? map_st[1][p] : map_st[2][p];
    end
  end

  always_comb begin
    for (int p = 0; p < 3; p++) begin
      case (pick)
        PICK_A:  live[p] = shd_a_q[p];
        PICK_B:  live[p] = shd_b_q[p];
        default: live[p] = shd_z_q[p];
      endcase
      lvl[p]    = err_q ? hold_q[p] : live[p];
      hold_d[p] = lvl[p];
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= TW'(TS_CYC - 1);
      err_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_bnd_q <= '0;
      for (int p = 0; p < 3; p++) begin
        shd_z_q[p] <= '0;
        shd_a_q[p] <= '0;
        shd_b_q[p] <= '0;
      end
    end else if (shd_en) begin
      shd_bnd_q <= shd_bnd_d;
      for (int p = 0; p < 3; p++) begin
        shd_z_q[p] <= shd_z_d[p];
        shd_a_q[p] <= shd_a_d[p];
        shd_b_q[p] <= shd_b_d[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++) hold_q[p] <= '0;
    end else if (!err_q) begin
      for (int p = 0; p < 3; p++) hold_q[p] <= hold_d[p];
    end
  end

  // ---------------- outputs ----------------
  assign lvl_u_o        = lvl[0];
  assign lvl_v_o        = lvl[1];
  assign lvl_w_o        = lvl[2];
  assign period_start_o = (pos_q == '0);
  assign dwell_err_o    = err_q;

endmodule

// File: rtl/svs_seq_chk.sv
module svs_seq_chk #(
  parameter int LW     = 3,
  parameter int TS_CYC = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [LW-1:0] lvl_u,
  input logic signed [LW-1:0] lvl_v,
  input logic signed [LW-1:0] lvl_w,
  input logic                 period_start,
  input logic                 dwell_err
);

  int unsigned          gap_q;
  int unsigned          chg_q;
  logic                 seen_q;
  logic signed [LW-1:0] pu_q, pv_q, pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      chg_q  <= 0;
      seen_q <= 1'b0;
      pu_q   <= '0;
      pv_q   <= '0;
      pw_q   <= '0;
    end else begin
      if (period_start) begin
        gap_q  <= 0;
        chg_q  <= 0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1;
        if (lvl_u != pu_q || lvl_v != pv_q || lvl_w != pw_q) chg_q <= chg_q + 1;
      end
      pu_q <= lvl_u;
      pv_q <= lvl_v;
      pw_q <= lvl_w;
    end
  end

  // R1
  period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (!seen_q || gap_q == TS_CYC - 1));

  // R3
  seg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q <= 6);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwell_err && !period_start) |-> ($stable(lvl_u) && $stable(lvl_v) && $stable(lvl_w)));

  // R7
  err_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(dwell_err));

endmodule

bind svs_sequencer svs_seq_chk #(.LW(LW), .TS_CYC(TS_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lvl_u        (lvl_u_o),
  .lvl_v        (lvl_v_o),
  .lvl_w        (lvl_w_o),
  .period_start (period_start_o),
  .dwell_err    (dwell_err_o)
);

// File: tb/svs_sequencer_test.sv
`timescale 1ns/1ps
module svs_sequencer_test;

  localparam int LEVELS = 7;
  localparam int TS     = 40;
  localparam int LW     = 3;
  localparam int TW     = 6;
  localparam int NPER   = 26;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  int c_sec;
  int c_t  [3];
  int c_st [3][3];

  logic signed [LW-1:0] lvl_u_o, lvl_v_o, lvl_w_o;
  logic period_start_o, dwell_err_o;

  svs_sequencer #(.LEVELS(LEVELS), .TS_CYC(TS)) uut (
    .clk(clk), .rst_n(rst_n), .sector_i(3'(c_sec)),
    .vz_u_i(LW'(c_st[0][0])), .vz_v_i(LW'(c_st[0][1])), .vz_w_i(LW'(c_st[0][2])),
    .v1_u_i(LW'(c_st[1][0])), .v1_v_i(LW'(c_st[1][1])), .v1_w_i(LW'(c_st[1][2])),
    .v2_u_i(LW'(c_st[2][0])), .v2_v_i(LW'(c_st[2][1])), .v2_w_i(LW'(c_st[2][2])),
    .t0_i(TW'(c_t[0])), .t1_i(TW'(c_t[1])), .t2_i(TW'(c_t[2])),
    .lvl_u_o(lvl_u_o), .lvl_v_o(lvl_v_o), .lvl_w_o(lvl_w_o),
    .period_start_o(period_start_o), .dwell_err_o(dwell_err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int    qu[$], qv[$], qw[$], qs[$], qe[$];
  string qtag[$];
  int    last_u = 0, last_v = 0, last_w = 0;
  bit    prev_bad = 0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic load_case(int i);
    int s, a, b, c;
    case (i)
      0:  begin s = 1; a = 9;  b = 13; c = 11; end
      1:  begin s = 2; a = 8;  b = 6;  c = 10; end
      2:  begin s = 3; a = 4;  b = 12; c = 7;  end
      3:  begin s = 4; a = 12; b = 3;  c = 14; end
      4:  begin s = 5; a = 5;  b = 9;  c = 9;  end
      5:  begin s = 6; a = 16; b = 8;  c = 4;  end
      6:  begin s = 3; a = 6;  b = 0;  c = 15; end
      7:  begin s = 4; a = 20; b = 10; c = 10; end
      8:  begin s = 2; a = 20; b = 11; c = 10; end
      9:  begin s = 5; a = 10; b = 8;  c = 6;  end
      10: begin s = 0; a = 4;  b = 4;  c = 4;  end
      11: begin s = 7; a = 4;  b = 4;  c = 4;  end
      12: begin s = 1; a = 0;  b = 1;  c = 0;  end
      default: begin s = (i % 6) + 1; a = (i * 7) % 15; b = (i * 5) % 13; c = (i * 3) % 12; end
    endcase
    c_sec = s; c_t[0] = a; c_t[1] = b; c_t[2] = c;
    for (int k = 0; k < 3; k++)
      for (int p = 0; p < 3; p++)
        c_st[k][p] = ((i * 3 + k * 5 + p * 2 + i * k) % 7) - 3;
  endtask

  task automatic scramble();
    c_sec = (c_sec % 6) + 1;
    c_t[0] = 1; c_t[1] = 30; c_t[2] = 2;
    for (int k = 0; k < 3; k++)
      for (int p = 0; p < 3; p++)
        c_st[k][p] = (c_st[k][p] == 2) ? -2 : 2;
  endtask

  // Build the whole expected period from the inputs present at the boundary.
  task automatic build();
    int  s, sum, r, sg, ia, ib, e, ha, hb, cen, n;
    bit  bad;
    string tag;
    int  vsel [7];
    int  vlen [7];
    s   = c_sec;
    sum = c_t[0] + c_t[1] + c_t[2];
    bad = (sum > TS) || (s < 1) || (s > 6);
    if (bad) begin
      tag = (s < 1 || s > 6) ? "R8" : "R7";
      for (int j = 0; j < TS; j++) begin
        qu.push_back(last_u); qv.push_back(last_v); qw.push_back(last_w);
        qs.push_back(j == 0); qe.push_back(1); qtag.push_back(tag);
      end
    end else begin
      if (prev_bad) tag = "R9";
      else if (c_t[1] == 0 || c_t[2] == 0 || c_t[0] < 4) tag = "R6";
      else if (s % 2 == 0) tag = "R4";
      else if (s != 1) tag = "R5";
      else tag = "R3";
      r  = (s - 1) % 3;
      sg = (s % 2 == 0) ? -1 : 1;
      ia = (s % 2 == 0) ? 2 : 1;
      ib = (s % 2 == 0) ? 1 : 2;
      e = c_t[0] / 4; ha = c_t[ia] / 2; hb = c_t[ib] / 2;
      cen = TS - 2 * e - 2 * ha - 2 * hb;
      vsel = '{0, ia, ib, 0, ib, ia, 0};
      vlen = '{e, ha, hb, cen, hb, ha, e};
      n = 0;
      for (int g = 0; g < 7; g++) begin
        for (int j = 0; j < vlen[g]; j++) begin
          last_u = sg * c_st[vsel[g]][(0 + r) % 3];
          last_v = sg * c_st[vsel[g]][(1 + r) % 3];
          last_w = sg * c_st[vsel[g]][(2 + r) % 3];
          qu.push_back(last_u); qv.push_back(last_v); qw.push_back(last_w);
          qs.push_back(n == 0); qe.push_back(0);
          qtag.push_back(n >= 12 ? "R2" : tag);
          n++;
        end
      end
    end
    prev_bad = bad;
  endtask

  initial begin : main
    int cu, cv, cw, cs, ce, pcnt, in_per;
    string ct;
    bit have;
    rst_n = 1'b0;
    load_case(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "lvl_u", int'(lvl_u_o), 0);
    check("R10", "lvl_v", int'(lvl_v_o), 0);
    check("R10", "lvl_w", int'(lvl_w_o), 0);
    check("R10", "period_start", int'(period_start_o), 0);
    check("R10", "dwell_err", int'(dwell_err_o), 0);
    rst_n = 1'b1;
    have = 0; pcnt = 0; in_per = 0;
    cu = 0; cv = 0; cw = 0; cs = 0; ce = 0; ct = "";
    forever begin
      if (have) begin
        check(ct, "lvl_u", int'(lvl_u_o), cu);
        check(ct, "lvl_v", int'(lvl_v_o), cv);
        check(ct, "lvl_w", int'(lvl_w_o), cw);
        check("R1", "period_start", int'(period_start_o), cs);
        check(ct, "dwell_err", int'(dwell_err_o), ce);
      end
      if (qu.size() == 0) begin
        if (pcnt == NPER) break;
        load_case(pcnt);
        build();
        pcnt++;
        in_per = 0;
      end else begin
        in_per++;
        // R2: inputs scrambled mid-period must not show until the next boundary
        if (in_per == 10) scramble();
      end
      cu = qu.pop_front(); cv = qv.pop_front(); cw = qw.pop_front();
      cs = qs.pop_front(); ce = qe.pop_front(); ct = qtag.pop_front();
      have = 1;
      @(negedge clk);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule